// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor that uses 4 KB pages. A 32-bit virtual address comes in with an access kind (load, store or instruction fetch). In the same cycle, all valid entries are compared against its 20-bit page number. On a permitted hit, the 12-bit page offset is joined to the stored physical page number. No page table is walked. A request that finds no valid translation raises a miss trap, and trap-handling software then finds the mapping itself. A request that finds a translation whose rights forbid the access raises a separate protection trap.

Software installs a translation through a write port. When the page number is already present, that entry is rewritten. Otherwise a victim is chosen. Each entry keeps a reference bit, set whenever the entry is used, and these bits steer an approximate least-recently-used choice around a rotating pointer. Each entry also keeps a dirty bit that records stores, so that paging software can tell whether the evicted page must be written back. The choice of victim is shown at the ports before the install happens. An invalidate-all input drops every translation at once when the running process changes.

Top module: `sw_tlb`

## Requirements
- R1: When `lk_valid` is high and a valid entry holds the requested page number with a permitted access, `lk_hit` is high in the same cycle. `lk_paddr` then equals the stored physical page number in bits 31:12 and the request's bits 11:0 unchanged.
- R2: When `lk_valid` is high and no valid entry matches, `lk_miss_trap` is high and the hit and protection outputs are low. When `lk_valid` is low, all three outputs are low.
- R3: A permitted hit sets the entry's reference bit at the next clock edge.
- R4: `lk_kind` encodes 0 = load, 1 = store, 2 = fetch and 3 = reserved. The rights field gives bit 0 = load allowed, bit 1 = store allowed and bit 2 = fetch allowed. The reserved kind is always denied. A matching but denied access raises `lk_prot_trap` instead of `lk_hit`, and it changes neither the reference bit nor the dirty bit.
- R5: A permitted store hit sets the entry's dirty bit. `lk_dirty` shows the matched entry's stored dirty bit as it was before the access. `victim_dirty` shows the dirty bit of the entry that the next install would replace.
- R6: If any entry is invalid, the victim is the invalid entry with the lowest index. Otherwise the victim is the first entry at or after the rotating pointer whose reference bit is clear. An install into a victim chosen by reference bits moves the pointer to the slot after the victim.
- R7: If every entry is valid and every reference bit is set, the victim is the pointer entry. When that install takes place, all other reference bits are cleared.
- R8: `flush_all` clears every valid bit in one cycle and overrides an install requested in the same cycle.
- R9: Installing a page number that is already valid rewrites that entry in place. It does not take the victim and does not move the pointer.
- R10: An installed entry starts valid, referenced and clean. A lookup made in the cycle of an install sees the state from before the install. If that lookup hits the entry being replaced, the install takes precedence.
- R11: After reset every entry is invalid and the pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind (0 load, 1 store, 2 fetch, 3 reserved) |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss_trap | output | 1 | No valid translation found |
| lk_prot_trap | output | 1 | Translation found but the access is denied |
| lk_paddr | output | 32 | Physical address on a hit |
| lk_dirty | output | 1 | Stored dirty bit of the matched entry |
| wr_en | input | 1 | Install a translation |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| wr_rights | input | 3 | Rights of the installed entry |
| flush_all | input | 1 | Invalidate every entry |
| victim_idx | output | 4 | Slot the next new install would use |
| victim_valid | output | 1 | That slot currently holds a translation |
| victim_dirty | output | 1 | That slot's dirty bit |
| victim_vpn | output | 20 | That slot's virtual page number |

## Verification
A lookup and an install can fall in the same clock cycle. In that cycle the lookup reads the old state while the install writes a new entry and may move the pointer. The bench drives both in one cycle, once with the lookup hitting an entry other than the victim and once with it hitting the victim itself. It checks that the lookup returns the old mapping in that cycle. It then checks the next victim, which shows whether the lookup's reference update survived, and looks up the old page again, which should now miss. A flush that arrives together with an install is judged the same way, by confirming afterwards that neither the old nor the new page translates.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int RIGHTS_W = 3;

  // rights bit 0 load, bit 1 store, bit 2 fetch; the reserved kind is never allowed
  function automatic logic kind_allowed(input logic [1:0] kind,
                                        input logic [RIGHTS_W-1:0] rights);
    logic ok;
    case (kind)
      ACC_LOAD:  ok = rights[0];
      ACC_STORE: ok = rights[1];
      ACC_FETCH: ok = rights[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VPN_W-1:0]    req_vpn,
  input  logic                hit_upd,
  input  logic                hit_store,
  input  logic [IDX_W-1:0]    hit_idx,
  input  logic                flush,
  input  logic                inst_fire,
  input  logic [IDX_W-1:0]    inst_idx,
  input  logic [VPN_W-1:0]    inst_vpn,
  input  logic [PPN_W-1:0]    inst_ppn,
  input  logic [RIGHTS_W-1:0] inst_rights,
  input  logic                sweep_apply,
  output logic [ENTRIES-1:0]  match_vec,
  output logic [ENTRIES-1:0]  inst_match_vec,
  output logic [ENTRIES-1:0]  valid_q,
  output logic [ENTRIES-1:0]  ref_q,
  output logic [ENTRIES-1:0]  dirty_q,
  output logic [VPN_W-1:0]    vpn_q    [ENTRIES],
  output logic [PPN_W-1:0]    ppn_q    [ENTRIES],
  output logic [RIGHTS_W-1:0] rights_q [ENTRIES]
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g]      = valid_q[g] && (vpn_q[g] == req_vpn);
    assign inst_match_vec[g] = valid_q[g] && (vpn_q[g] == inst_vpn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]    <= '0;
        ppn_q[i]    <= '0;
        rights_q[i] <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (sweep_apply) ref_q[i] <= 1'b0;
        if (hit_upd && (hit_idx == IDX_W'(i))) begin
          ref_q[i] <= 1'b1;
          if (hit_store) dirty_q[i] <= 1'b1;
        end
        if (inst_fire && (inst_idx == IDX_W'(i))) begin
          valid_q[i]  <= 1'b1;
          ref_q[i]    <= 1'b1;
          dirty_q[i]  <= 1'b0;
          vpn_q[i]    <= inst_vpn;
          ppn_q[i]    <= inst_ppn;
          rights_q[i] <= inst_rights;
        end
      end
    end
  end

  AST_MATCH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)) else $error("duplicate translation");  // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)) else $error("flush left a valid entry");  // R8
  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_fire && !flush) |=> (valid_q[$past(inst_idx)] && ref_q[$past(inst_idx)]
                               && !dirty_q[$past(inst_idx)])) else $error("install state");  // R10
  AST_REF_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_upd && !flush) |=> ref_q[$past(hit_idx)]) else $error("ref not set");  // R3
  AST_DIRTY_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ((dirty_q & ~$past(dirty_q)) != '0) |-> $past(hit_upd && hit_store))
    else $error("dirty set without store hit");  // R5
  AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_apply && !flush) |=> ($countones(ref_q) <= 2)) else $error("sweep incomplete");  // R7

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] ref_vec,
  input  logic               consume,
  output logic [IDX_W-1:0]   victim_idx,
  output logic               sweep,
  output logic               from_free
);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W:0]   free_pick;
  logic [IDX_W:0]   clear_pick;

  // lowest set bit: {found, index}
  function automatic logic [IDX_W:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  // first set bit at or after start, wrapping around: {found, index}
  function automatic logic [IDX_W:0] rotate_set(input logic [ENTRIES-1:0] v,
                                                input logic [IDX_W-1:0] start);
    logic [IDX_W:0] r;
    int j;
    r = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      j = (int'(start) + k) % ENTRIES;
      if (v[j]) r = {1'b1, IDX_W'(j)};
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (int'(p) == ENTRIES - 1) ? '0 : p + 1'b1;
  endfunction

  assign free_pick  = lowest_set(~valid_vec);
  assign clear_pick = rotate_set(~ref_vec, ptr_q);
  assign from_free  = free_pick[IDX_W];
  assign sweep      = !from_free && !clear_pick[IDX_W];

  always_comb begin
    if (from_free)         victim_idx = free_pick[IDX_W-1:0];
    else if (!sweep)       victim_idx = clear_pick[IDX_W-1:0];
    else                   victim_idx = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ptr_q <= '0;
    else if (consume && !from_free) ptr_q <= step(victim_idx);
  end

  AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec != '1) |-> !valid_vec[victim_idx]) else $error("valid victim while free slot");  // R6
  AST_VICTIM_UNREF: assert property (@(posedge clk) disable iff (!rst_n)
    (!from_free && !sweep) |-> !ref_vec[victim_idx]) else $error("referenced victim");  // R6
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !from_free) |=> (ptr_q == step($past(victim_idx)))) else $error("pointer");  // R6
  AST_SWEEP_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    sweep |-> (victim_idx == ptr_q && ref_vec == '1)) else $error("sweep victim");  // R7

endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [OFS_W-1:0]    req_ofs,
  input  logic [ENTRIES-1:0]  match_vec,
  input  logic [ENTRIES-1:0]  dirty_vec,
  input  logic [PPN_W-1:0]    ppn_arr    [ENTRIES],
  input  logic [RIGHTS_W-1:0] rights_arr [ENTRIES],
  output logic                hit,
  output logic                miss,
  output logic                prot,
  output logic [PPN_W+OFS_W-1:0] paddr,
  output logic                dirty,
  output logic [IDX_W-1:0]    hit_idx,
  output logic                store_hit
);

  logic any_match;
  logic allowed;

  function automatic logic [IDX_W-1:0] match_index(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  assign any_match = |match_vec;
  assign hit_idx   = match_index(match_vec);
  assign allowed   = kind_allowed(req_kind, rights_arr[hit_idx]);
  assign hit       = req_valid && any_match && allowed;
  assign prot      = req_valid && any_match && !allowed;
  assign miss      = req_valid && !any_match;
  assign paddr     = {ppn_arr[hit_idx], req_ofs};
  assign dirty     = any_match && dirty_vec[hit_idx];
  assign store_hit = hit && (req_kind == ACC_STORE);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $onehot({hit, miss, prot})) else $error("outcome not unique");  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(hit || miss || prot)) else $error("trap while idle");  // R2
  AST_RSVD_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == ACC_RSVD) |-> !hit) else $error("reserved kind hit");  // R4

endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFS_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFS_W,
  localparam int PA_W   = PPN_W + OFS_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic [VA_W-1:0]     lk_vaddr,
  input  logic [1:0]          lk_kind,
  output logic                lk_hit,
  output logic                lk_miss_trap,
  output logic                lk_prot_trap,
  output logic [PA_W-1:0]     lk_paddr,
  output logic                lk_dirty,
  input  logic                wr_en,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic                flush_all,
  output logic [IDX_W-1:0]    victim_idx,
  output logic                victim_valid,
  output logic                victim_dirty,
  output logic [VPN_W-1:0]    victim_vpn
);

  logic [ENTRIES-1:0]  match_vec, inst_match_vec, valid_q, ref_q, dirty_q;
  logic [VPN_W-1:0]    vpn_q    [ENTRIES];
  logic [PPN_W-1:0]    ppn_q    [ENTRIES];
  logic [RIGHTS_W-1:0] rights_q [ENTRIES];
  logic [IDX_W-1:0]    hit_idx, inst_idx, rewrite_idx;
  logic                store_hit, hit_upd, inst_fire, rewrite, use_victim;
  logic                sweep, from_free, sweep_apply;

  function automatic logic [IDX_W-1:0] vec_index(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  assign inst_fire   = wr_en && !flush_all;
  assign rewrite     = |inst_match_vec;
  assign rewrite_idx = vec_index(inst_match_vec);
  assign use_victim  = inst_fire && !rewrite;
  assign inst_idx    = rewrite ? rewrite_idx : victim_idx;
  assign sweep_apply = use_victim && sweep;
  assign hit_upd     = lk_hit;

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .req_vpn(lk_vaddr[VA_W-1:OFS_W]),
    .hit_upd(hit_upd), .hit_store(store_hit), .hit_idx(hit_idx),
    .flush(flush_all),
    .inst_fire(inst_fire), .inst_idx(inst_idx), .inst_vpn(wr_vpn),
    .inst_ppn(wr_ppn), .inst_rights(wr_rights), .sweep_apply(sweep_apply),
    .match_vec(match_vec), .inst_match_vec(inst_match_vec),
    .valid_q(valid_q), .ref_q(ref_q), .dirty_q(dirty_q),
    .vpn_q(vpn_q), .ppn_q(ppn_q), .rights_q(rights_q)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_q), .ref_vec(ref_q), .consume(use_victim),
    .victim_idx(victim_idx), .sweep(sweep), .from_free(from_free)
  );

  tlb_check #(.ENTRIES(ENTRIES), .PPN_W(PPN_W), .OFS_W(OFS_W)) u_check (
    .clk(clk), .rst_n(rst_n),
    .req_valid(lk_valid), .req_kind(lk_kind), .req_ofs(lk_vaddr[OFS_W-1:0]),
    .match_vec(match_vec), .dirty_vec(dirty_q),
    .ppn_arr(ppn_q), .rights_arr(rights_q),
    .hit(lk_hit), .miss(lk_miss_trap), .prot(lk_prot_trap),
    .paddr(lk_paddr), .dirty(lk_dirty), .hit_idx(hit_idx), .store_hit(store_hit)
  );

  assign victim_valid = valid_q[victim_idx];
  assign victim_dirty = dirty_q[victim_idx];
  assign victim_vpn   = vpn_q[victim_idx];

  AST_REWRITE_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_fire && rewrite) |=> ($countones(valid_q) == $countones($past(valid_q))))
    else $error("rewrite changed occupancy");  // R9
  AST_FLUSH_BEATS_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && wr_en) |=> !victim_valid) else $error("install survived flush");  // R8

endmodule

// File: tb/sw_tlb_tb.sv
`timescale 1ns/1ps
module sw_tlb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_kind = '0;
  logic        lk_hit, lk_miss_trap, lk_prot_trap, lk_dirty;
  logic [31:0] lk_paddr;
  logic        wr_en = 1'b0;
  logic [19:0] wr_vpn = '0, wr_ppn = '0;
  logic [2:0]  wr_rights = '0;
  logic        flush_all = 1'b0;
  logic [3:0]  victim_idx;
  logic        victim_valid, victim_dirty;
  logic [19:0] victim_vpn;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic        hit, miss, prot, dirty;
    logic [31:0] paddr;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  sw_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_miss_trap(lk_miss_trap),
    .lk_prot_trap(lk_prot_trap), .lk_paddr(lk_paddr), .lk_dirty(lk_dirty),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_rights(wr_rights),
    .flush_all(flush_all), .victim_idx(victim_idx), .victim_valid(victim_valid),
    .victim_dirty(victim_dirty), .victim_vpn(victim_vpn)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares lookup outcomes one nanosecond after each falling edge
  always @(negedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check({lk_hit, lk_miss_trap, lk_prot_trap} == {e.hit, e.miss, e.prot}, e.req,
            {lk_hit, lk_miss_trap, lk_prot_trap}, {e.hit, e.miss, e.prot});
      if (e.hit) begin
        check(lk_paddr == e.paddr, e.req, lk_paddr, e.paddr);
        check(lk_dirty == e.dirty, e.req, lk_dirty, e.dirty);
      end
    end
  end

  task automatic push(input logic h, input logic m, input logic p, input logic [31:0] pa,
                      input logic d, input string req);
    exp_t e;
    e.hit = h; e.miss = m; e.prot = p; e.paddr = pa; e.dirty = d; e.req = req;
    sb.push_back(e);
  endtask

  // driver: a lookup only; expected outcome is queued for the monitor
  task automatic lookup(input logic v, input logic [19:0] vpn, input logic [11:0] ofs,
                        input logic [1:0] kind, input logic h, input logic m,
                        input logic p, input logic [19:0] ppn, input logic d,
                        input string req);
    @(negedge clk);
    wr_en = 0; flush_all = 0;
    lk_valid = v; lk_vaddr = {vpn, ofs}; lk_kind = kind;
    push(h, m, p, {ppn, ofs}, d, req);
  endtask

  task automatic install(input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic [2:0] rights);
    @(negedge clk);
    lk_valid = 0; flush_all = 0;
    wr_en = 1; wr_vpn = vpn; wr_ppn = ppn; wr_rights = rights;
  endtask

  // lookup that hits and an install in the same cycle
  task automatic collide(input logic [19:0] lvpn, input logic [19:0] lppn,
                         input logic [19:0] ivpn, input logic [19:0] ippn, input string req);
    @(negedge clk);
    flush_all = 0;
    lk_valid = 1; lk_vaddr = {lvpn, 12'h3c4}; lk_kind = 2'd0;
    wr_en = 1; wr_vpn = ivpn; wr_ppn = ippn; wr_rights = 3'b011;
    push(1, 0, 0, {lppn, 12'h3c4}, 0, req);
  endtask

  task automatic check_victim(input logic [3:0] idx, input logic v, input logic d,
                              input logic [19:0] vpn, input string req);
    @(negedge clk);
    lk_valid = 0; wr_en = 0; flush_all = 0;
    #1;
    check(victim_idx == idx, req, victim_idx, idx);
    check(victim_valid == v, req, victim_valid, v);
    if (v) begin
      check(victim_dirty == d, req, victim_dirty, d);
      check(victim_vpn == vpn, req, victim_vpn, vpn);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state
    check_victim(4'd0, 1'b0, 1'b0, 20'h0, "R11 reset victim");
    lookup(1, 20'h00005, 12'h010, 2'd0, 0, 1, 0, 20'h0, 0, "R2 miss after reset");
    lookup(0, 20'h00005, 12'h010, 2'd0, 0, 0, 0, 20'h0, 0, "R2 idle no trap");

    // fill: entry 3 load-only, entry 4 fetch-only, others load/store
    for (int i = 0; i < 16; i++) begin
      check_victim(4'(i), 1'b0, 1'b0, 20'h0, "R6 lowest free slot");
      install(20'h100 + 20'(i), 20'h800 + 20'(i),
              (i == 3) ? 3'b001 : (i == 4) ? 3'b100 : 3'b011);
    end
    check_victim(4'd0, 1'b1, 1'b0, 20'h100, "R7 all referenced picks pointer");

    lookup(1, 20'h105, 12'habc, 2'd0, 1, 0, 0, 20'h805, 0, "R1 load hit");
    lookup(1, 20'h105, 12'h004, 2'd1, 1, 0, 0, 20'h805, 0, "R5 store hit clean before");
    lookup(1, 20'h105, 12'hfff, 2'd0, 1, 0, 0, 20'h805, 1, "R5 dirty after store");
    lookup(1, 20'h103, 12'h020, 2'd1, 0, 0, 1, 20'h0, 0, "R4 store to load-only");
    lookup(1, 20'h103, 12'h020, 2'd0, 1, 0, 0, 20'h803, 0, "R4 denied store left clean");
    lookup(1, 20'h104, 12'h100, 2'd2, 1, 0, 0, 20'h804, 0, "R4 fetch allowed");
    lookup(1, 20'h104, 12'h100, 2'd0, 0, 0, 1, 20'h0, 0, "R4 load on fetch-only");

    install(20'h200, 20'h900, 3'b011);
    check_victim(4'd1, 1'b1, 1'b0, 20'h101, "R7 sweep then rotate");
    lookup(1, 20'h200, 12'h0aa, 2'd0, 1, 0, 0, 20'h900, 0, "R10 new entry clean");
    lookup(1, 20'h100, 12'h0aa, 2'd0, 0, 1, 0, 20'h0, 0, "R2 evicted page misses");

    lookup(1, 20'h101, 12'h000, 2'd0, 1, 0, 0, 20'h801, 0, "R3 hit entry 1");
    check_victim(4'd2, 1'b1, 1'b0, 20'h102, "R3 referenced slot skipped");
    lookup(1, 20'h102, 12'h000, 2'd0, 1, 0, 0, 20'h802, 0, "R3 hit entry 2");
    lookup(1, 20'h103, 12'h000, 2'd0, 1, 0, 0, 20'h803, 0, "R3 hit entry 3");
    lookup(1, 20'h104, 12'h000, 2'd2, 1, 0, 0, 20'h804, 0, "R3 hit entry 4");
    check_victim(4'd5, 1'b1, 1'b1, 20'h105, "R5 dirty victim reported");

    install(20'h300, 20'ha00, 3'b011);
    lookup(1, 20'h105, 12'h000, 2'd0, 0, 1, 0, 20'h0, 0, "R6 replaced slot misses");
    lookup(1, 20'h300, 12'h55a, 2'd1, 1, 0, 0, 20'ha00, 0, "R10 installed clean");

    install(20'h10a, 20'hb0a, 3'b011);
    check_victim(4'd6, 1'b1, 1'b0, 20'h106, "R9 rewrite keeps pointer");
    lookup(1, 20'h10a, 12'h777, 2'd0, 1, 0, 0, 20'hb0a, 0, "R9 rewritten mapping");

    collide(20'h107, 20'h807, 20'h400, 20'hc00, "R10 lookup sees old state");
    check_victim(4'd8, 1'b1, 1'b0, 20'h108, "R10 same-cycle ref update kept");
    collide(20'h108, 20'h808, 20'h500, 20'hd00, "R10 lookup on victim");
    lookup(1, 20'h108, 12'h000, 2'd0, 0, 1, 0, 20'h0, 0, "R10 install wins");
    lookup(1, 20'h500, 12'h123, 2'd0, 1, 0, 0, 20'hd00, 0, "R10 install landed");
    check_victim(4'd9, 1'b1, 1'b0, 20'h109, "R6 pointer after collision");

    @(negedge clk);
    lk_valid = 0; flush_all = 1;
    wr_en = 1; wr_vpn = 20'h600; wr_ppn = 20'he00; wr_rights = 3'b011;
    check_victim(4'd0, 1'b0, 1'b0, 20'h0, "R8 flush empties");
    lookup(1, 20'h300, 12'h000, 2'd0, 0, 1, 0, 20'h0, 0, "R8 old page gone");
    lookup(1, 20'h600, 12'h000, 2'd0, 0, 1, 0, 20'h0, 0, "R8 install overridden");

    install(20'h700, 20'hf00, 3'b111);
    lookup(1, 20'h700, 12'h010, 2'd3, 0, 0, 1, 20'h0, 0, "R4 reserved kind denied");
    lookup(1, 20'h700, 12'h010, 2'd2, 1, 0, 0, 20'hf00, 0, "R1 fetch hit");
    @(negedge clk);
    lk_valid = 0; wr_en = 0;
    @(negedge clk);
    #2;
    finish_run();
  end

endmodule